// File: doc/BRIEF.md
# Bus Transceiver Power-Mode Supervisor

This block is the digital supervisor of a single-wire bus transceiver that carries its own low-drop regulator. It tracks five power modes: off (no supply), pre-normal, normal, silent and sleep. It takes already-digitised flags for supply valid, regulator undervoltage, bus wake request and local wake request, plus the raw enable (EN) and transmit data (TXD) pins. From these it drives the regulator enable, the regulator tolerance select, the transmit path enable, the bus termination enable, a force-low for the receive output and the active-low reset output for the attached controller. All timing comes from a 1 µs tick input.

The controller leaves normal mode on a falling EN edge. The TXD level is sampled a programmable number of ticks after that edge. A high level selects silent mode, where the regulator stays on at the looser tolerance. A low level selects sleep mode, where the regulator is off. A reset hold-off timer keeps the reset output low until the regulator has run without undervoltage for a programmed number of ticks, and no mode change out of pre-normal is accepted while it runs. Both EN and TXD pass through two-flop synchronisers, so every pin-driven decision lags its pin by two clock cycles.

Top module: `xcvr_mode_ctl`

## Requirements
- R1: While reset is asserted, and after reset with the supply flag low, the mode output is 3'b000 (off) and every control output is low, the reset output included.
- R2: When the supply flag is high in off mode, the block enters pre-normal (3'b001) on the next cycle at any EN level. Pre-normal has the regulator on at tight tolerance and termination on, with transmit off.
- R3: The reset output goes high only after HOLD_TICKS ticks in which the regulator was on and the undervoltage flag was low. Any undervoltage cycle restarts the count.
- R4: In pre-normal, a synchronised EN high moves the block to normal (3'b011) only once the hold-off has ended. Normal is the only mode with the transmit path enabled.
- R5: A falling EN edge in normal with TXD high at the sample point selects silent (3'b110). Silent has the regulator on at the looser tolerance, termination off and the reset output high.
- R6: A falling EN edge in normal with TXD low at the sample point selects sleep (3'b100). Sleep has the regulator off, the reset output low and the receive force-low set.
- R7: TXD is sampled on the SEL_TICKS-th tick after the EN falling edge is seen. A TXD change between the edge and that tick decides the mode.
- R8: An undervoltage flag in normal or silent moves the block to pre-normal and drives the reset output low on the same edge. This takes priority over a mode choice due in that cycle.
- R9: An undervoltage flag in sleep is ignored and the block stays in sleep.
- R10: A bus wake request in silent or sleep moves the block to pre-normal, with the regulator and termination back on.
- R11: A local wake request with EN high moves silent directly to normal, and sleep to pre-normal.
- R12: A low supply flag moves the block to off mode from any mode on the next edge, with priority over every other input.
- R13: EN going high again before the sample tick cancels the selection, and the block stays in normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| supply_ok | input | 1 | Battery supply above the lower threshold |
| vcc_uv | input | 1 | Regulator output below its undervoltage threshold |
| bus_wake | input | 1 | Filtered remote wake request from the bus |
| local_wake | input | 1 | Local wake request |
| en_in | input | 1 | Raw enable pin level |
| txd_in | input | 1 | Raw transmit data pin level |
| mode_o | output | 3 | Current mode: 000 off, 001 pre-normal, 011 normal, 110 silent, 100 sleep |
| reg_en | output | 1 | Regulator enable |
| reg_tight | output | 1 | 1 selects tight regulator tolerance, 0 the loose one |
| tx_en | output | 1 | Transmit and receive path enable |
| term_en | output | 1 | Bus termination enable (0 leaves only the weak pull-up) |
| rx_force_low | output | 1 | Forces the receive output low |
| nres_n | output | 1 | Active-low reset to the controller |

## Verification
The TXD sample decision and a regulator undervoltage can land on the same clock edge. Undervoltage must win, leaving the block in pre-normal with the reset output low rather than in silent. The bench provokes this by stopping the tick after an EN falling edge, stepping the tick by hand, and raising the undervoltage flag together with the final sampling tick. A second collision drops the supply in the same cycle as a bus wake in silent, and the result must be off mode.

// File: rtl/xcvr_mode_pkg.sv
`timescale 1ns/1ps
package xcvr_mode_pkg;

    // Mode codes. Any other code recovers to pre-normal.
    typedef enum logic [2:0] {
        MODE_OFF   = 3'b000,
        MODE_PRE   = 3'b001,
        MODE_NORM  = 3'b011,
        MODE_QUIET = 3'b110,
        MODE_DORM  = 3'b100
    } mode_e;

    // Modes in which the regulator runs.
    function automatic logic mode_reg_on(input mode_e m);
        return (m == MODE_PRE) || (m == MODE_NORM) || (m == MODE_QUIET);
    endfunction

endpackage

// File: rtl/xcvr_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser, one chain per bit, with a per-bit reset value.
module xcvr_sync #(
    parameter int unsigned   W       = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        typedef struct packed {
            logic s1;
            logic s2;
        } chain_t;

        chain_t c_d, c_q;

        always_comb begin
            c_d.s1 = d[b];
            c_d.s2 = c_q.s1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q <= '{s1: RST_VAL[b], s2: RST_VAL[b]};
            end else begin
                c_q <= c_d;
            end
        end

        assign q[b] = c_q.s2;
    end
endmodule

// File: rtl/xcvr_rst_hold.sv
`timescale 1ns/1ps
// Reset hold-off: counts ticks of a healthy, running regulator.
module xcvr_rst_hold #(
    parameter int unsigned HOLD_TICKS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic reg_on,
    input  logic vcc_uv,
    output logic hold_done
);
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] CNT_END = CW'(HOLD_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!reg_on || vcc_uv) begin
            h_d.cnt = '0;
        end else if (tick && (h_q.cnt != CNT_END)) begin
            h_d.cnt = h_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign hold_done = (h_q.cnt == CNT_END);
endmodule

// File: rtl/xcvr_sel_window.sv
`timescale 1ns/1ps
// Mode-select window: after arming, the TXD level is taken on the
// SEL_TICKS-th tick unless the window is aborted first.
module xcvr_sel_window #(
    parameter int unsigned SEL_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic abort,
    input  logic txd_lvl,
    output logic pick,
    output logic pick_quiet
);
    localparam int unsigned CW = (SEL_TICKS < 2) ? 1 : $clog2(SEL_TICKS);
    localparam logic [CW-1:0] CNT_LAST = CW'(SEL_TICKS - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        pick       = w_q.active && !abort && tick && (w_q.cnt == CNT_LAST);
        pick_quiet = txd_lvl;

        w_d = w_q;
        if (abort) begin
            w_d.active = 1'b0;
            w_d.cnt    = '0;
        end else if (arm) begin
            w_d.active = 1'b1;
            w_d.cnt    = '0;
        end else if (pick) begin
            w_d.active = 1'b0;
            w_d.cnt    = '0;
        end else if (w_q.active && tick) begin
            w_d.cnt = w_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end
endmodule

// File: rtl/xcvr_mode_ctl.sv
`timescale 1ns/1ps
module xcvr_mode_ctl
    import xcvr_mode_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 10000,
    parameter int unsigned SEL_TICKS  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       supply_ok,
    input  logic       vcc_uv,
    input  logic       bus_wake,
    input  logic       local_wake,
    input  logic       en_in,
    input  logic       txd_in,
    output logic [2:0] mode_o,
    output logic       reg_en,
    output logic       reg_tight,
    output logic       tx_en,
    output logic       term_en,
    output logic       rx_force_low,
    output logic       nres_n
);
    // Synchronised pins: bit 0 EN (resets low), bit 1 TXD (resets recessive high).
    localparam logic [1:0] PIN_RST = 2'b10;

    typedef struct packed {
        mode_e mode;
        logic  en_prev;
    } ctl_t;

    ctl_t       s_d, s_q;
    logic [1:0] pins_s;
    logic       en_s, txd_s;
    logic       hold_done;
    logic       reg_on_q;
    logic       arm, abort;
    logic       pick, pick_quiet;

    xcvr_sync #(.W(2), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({txd_in, en_in}),
        .q     (pins_s)
    );

    assign en_s  = pins_s[0];
    assign txd_s = pins_s[1];

    assign reg_on_q = mode_reg_on(s_q.mode);

    xcvr_rst_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_us),
        .reg_on    (reg_on_q),
        .vcc_uv    (vcc_uv),
        .hold_done (hold_done)
    );

    assign arm   = (s_q.mode == MODE_NORM) && s_q.en_prev && !en_s;
    assign abort = (s_q.mode != MODE_NORM) || en_s;

    xcvr_sel_window #(.SEL_TICKS(SEL_TICKS)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_us),
        .arm        (arm),
        .abort      (abort),
        .txd_lvl    (txd_s),
        .pick       (pick),
        .pick_quiet (pick_quiet)
    );

    always_comb begin
        s_d         = s_q;
        s_d.en_prev = en_s;
        unique case (s_q.mode)
            MODE_OFF: begin
                if (supply_ok) s_d.mode = MODE_PRE;
            end
            MODE_PRE: begin
                if (en_s && hold_done) s_d.mode = MODE_NORM;
            end
            MODE_NORM: begin
                if (vcc_uv) begin
                    s_d.mode = MODE_PRE;
                end else if (pick) begin
                    s_d.mode = pick_quiet ? MODE_QUIET : MODE_DORM;
                end
            end
            MODE_QUIET: begin
                if (vcc_uv || bus_wake) begin
                    s_d.mode = MODE_PRE;
                end else if (local_wake && en_s) begin
                    s_d.mode = MODE_NORM;
                end
            end
            MODE_DORM: begin
                if (bus_wake || (local_wake && en_s)) s_d.mode = MODE_PRE;
            end
            default: s_d.mode = MODE_PRE;
        endcase
        if (!supply_ok) s_d.mode = MODE_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_OFF, en_prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o       = s_q.mode;
    assign reg_en       = reg_on_q;
    assign reg_tight    = (s_q.mode == MODE_PRE) || (s_q.mode == MODE_NORM);
    assign tx_en        = (s_q.mode == MODE_NORM);
    assign term_en      = (s_q.mode == MODE_PRE) || (s_q.mode == MODE_NORM);
    assign rx_force_low = (s_q.mode == MODE_DORM);
    assign nres_n       = reg_on_q && hold_done;
endmodule

// File: rtl/xcvr_mode_chk.sv
`timescale 1ns/1ps
module xcvr_mode_chk
    import xcvr_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       vcc_uv,
    input logic       bus_wake,
    input logic       local_wake,
    input logic [2:0] mode_o,
    input logic       reg_en,
    input logic       term_en,
    input logic       nres_n
);
    AST_POWER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_OFF && supply_ok) |=> (mode_o == MODE_PRE)); // R2

    AST_NRES_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nres_n) |-> ($past(!vcc_uv) && $past(reg_en))); // R3

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_PRE && !nres_n) |=> (mode_o != MODE_NORM)); // R4

    AST_UV_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && vcc_uv && (mode_o == MODE_NORM || mode_o == MODE_QUIET))
        |=> (mode_o == MODE_PRE && !nres_n)); // R8

    AST_SLEEP_UV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && vcc_uv && mode_o == MODE_DORM && !bus_wake && !local_wake)
        |=> (mode_o == MODE_DORM)); // R9

    AST_BUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && bus_wake && (mode_o == MODE_QUIET || mode_o == MODE_DORM))
        |=> (mode_o == MODE_PRE && reg_en && term_en)); // R10

    AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (mode_o == MODE_OFF && !nres_n)); // R12
endmodule

bind xcvr_mode_ctl xcvr_mode_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .vcc_uv     (vcc_uv),
    .bus_wake   (bus_wake),
    .local_wake (local_wake),
    .mode_o     (mode_o),
    .reg_en     (reg_en),
    .term_en    (term_en),
    .nres_n     (nres_n)
);

// File: tb/tb_xcvr_mode_ctl.sv
`timescale 1ns/1ps
module tb_xcvr_mode_ctl;
    localparam int unsigned HOLD = 20;
    localparam int unsigned SEL  = 3;

    // Expected {mode, reg_en, reg_tight, tx_en, term_en, nres_n, rx_force_low}
    localparam logic [8:0] E_OFF   = {3'b000, 6'b000000};
    localparam logic [8:0] E_PRE_H = {3'b001, 6'b110100};
    localparam logic [8:0] E_PRE_R = {3'b001, 6'b110110};
    localparam logic [8:0] E_NORM  = {3'b011, 6'b111110};
    localparam logic [8:0] E_QUIET = {3'b110, 6'b100010};
    localparam logic [8:0] E_DORM  = {3'b100, 6'b000001};

    typedef struct packed {
        logic       sup;
        logic       uv;
        logic       bw;
        logic       lw;
        logic       en;
        logic       txd;
        logic [7:0] wt;
        logic [8:0] exp_v;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd5,  E_PRE_H, 8'd2 },  // R2 power up
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd10, E_PRE_H, 8'd4 },  // R4 EN high blocked
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd20, E_NORM,  8'd3 },  // R3 hold-off over
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'd10, E_QUIET, 8'd5 },  // R5 to silent
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 8'd3,  E_PRE_R, 8'd10},  // R10 wake from silent
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd6,  E_NORM,  8'd4 },  // R4 back to normal
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd10, E_DORM,  8'd6 },  // R6 to sleep
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd5,  E_DORM,  8'd9 },  // R9 uv in sleep
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd5,  E_PRE_H, 8'd10},  // R10 wake from sleep
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd30, E_NORM,  8'd3 },  // R3 hold-off again
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'd10, E_QUIET, 8'd5 },  // R5
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 8'd6,  E_NORM,  8'd11},  // R11 silent -> normal
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd10, E_DORM,  8'd6 },  // R6
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 8'd6,  E_PRE_H, 8'd11},  // R11 sleep -> pre-normal
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd30, E_NORM,  8'd4 },  // R4
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 8'd4,  E_PRE_H, 8'd8 },  // R8 uv in normal
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd4,  E_OFF,   8'd12}   // R12 supply lost
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       supply_ok = 1'b0;
    logic       vcc_uv = 1'b0;
    logic       bus_wake = 1'b0;
    logic       local_wake = 1'b0;
    logic       en_in = 1'b0;
    logic       txd_in = 1'b1;
    logic [2:0] mode_o;
    logic       reg_en, reg_tight, tx_en, term_en, rx_force_low, nres_n;

    int  total = 0;
    int  bad = 0;
    bit  fin = 1'b0;

    always #10 clk = ~clk;

    xcvr_mode_ctl #(.HOLD_TICKS(HOLD), .SEL_TICKS(SEL)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_us      (tick_us),
        .supply_ok    (supply_ok),
        .vcc_uv       (vcc_uv),
        .bus_wake     (bus_wake),
        .local_wake   (local_wake),
        .en_in        (en_in),
        .txd_in       (txd_in),
        .mode_o       (mode_o),
        .reg_en       (reg_en),
        .reg_tight    (reg_tight),
        .tx_en        (tx_en),
        .term_en      (term_en),
        .rx_force_low (rx_force_low),
        .nres_n       (nres_n)
    );

    function automatic logic [8:0] obs();
        return {mode_o, reg_en, reg_tight, tx_en, term_en, nres_n, rx_force_low};
    endfunction

    task automatic check(input string tag, input logic [8:0] exp_v);
        logic [8:0] act;
        act = obs();
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp_v);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_tick(input logic with_uv);
        tick_us = 1'b1;
        vcc_uv  = with_uv;
        @(posedge clk);
        @(negedge clk);
        tick_us = 1'b0;
        vcc_uv  = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then idle with no supply
        wait_cyc(2);
        check("R1 in reset", E_OFF);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1 after reset, no supply", E_OFF);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            supply_ok  = TBL[i].sup;
            vcc_uv     = TBL[i].uv;
            bus_wake   = TBL[i].bw;
            local_wake = TBL[i].lw;
            en_in      = TBL[i].en;
            txd_in     = TBL[i].txd;
            wait_cyc(int'(TBL[i].wt));
            check($sformatf("row %0d R%0d", i, TBL[i].req), TBL[i].exp_v);
        end

        // Bring up to normal again
        supply_ok = 1'b1; vcc_uv = 1'b0; bus_wake = 1'b0; local_wake = 1'b0;
        en_in = 1'b1; txd_in = 1'b1;
        wait_cyc(40);
        check("R4 normal after restart", E_NORM);

        // R7: TXD low at the edge, high at the sample tick -> silent
        tick_us = 1'b0;
        txd_in  = 1'b0;
        wait_cyc(3);
        en_in = 1'b0;
        wait_cyc(4);
        txd_in = 1'b1;
        wait_cyc(3);
        check("R7 still normal before ticks", E_NORM);
        pulse_tick(1'b0);
        pulse_tick(1'b0);
        check("R7 normal before last tick", E_NORM);
        pulse_tick(1'b0);
        check("R7 sampled level decides", E_QUIET);

        // Back to normal via local wake (R11)
        tick_us = 1'b1;
        local_wake = 1'b1; en_in = 1'b1;
        wait_cyc(6);
        local_wake = 1'b0;
        check("R11 silent to normal", E_NORM);

        // Collision: undervoltage on the sampling tick (R8 wins over R5)
        tick_us = 1'b0;
        txd_in = 1'b1;
        en_in  = 1'b0;
        wait_cyc(4);
        pulse_tick(1'b0);
        pulse_tick(1'b0);
        pulse_tick(1'b1);
        check("R8 undervoltage beats mode pick", E_PRE_H);
        tick_us = 1'b1;
        wait_cyc(30);
        check("R8 stays pre-normal with EN low", E_PRE_R);
        en_in = 1'b1;
        wait_cyc(6);
        check("R4 normal after uv recovery", E_NORM);

        // R13: EN back high inside the window cancels the selection
        tick_us = 1'b0;
        en_in = 1'b0;
        wait_cyc(4);
        en_in = 1'b1;
        wait_cyc(4);
        tick_us = 1'b1;
        wait_cyc(10);
        check("R13 cancelled selection keeps normal", E_NORM);

        // Collision: supply loss with bus wake in silent (R12)
        en_in = 1'b0; txd_in = 1'b1;
        wait_cyc(10);
        check("R5 silent before supply loss", E_QUIET);
        supply_ok = 1'b0;
        bus_wake  = 1'b1;
        wait_cyc(1);
        check("R12 supply loss beats bus wake", E_OFF);
        bus_wake = 1'b0;

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule